// File: doc/BRIEF.md
# Water-Level Aligned Transmit Bit FIFO

This block buffers a serial payload bit stream on its way from a PCM frame into one HDSL transmit channel. It divides a master sync pulse train by a programmable count to recover the PCM frame sync. After that sync it waits a programmed number of transmit-clock enables before it declares the start of the first HDSL frame. The FIFO therefore holds a chosen amount of data, the water level, when extraction begins. Each HDSL frame opens with 16 bit times of sync word and overhead, during which the FIFO is not read. Payload bits are then taken one per transmit enable for the programmed block length.

The alignment is set up only when the processor issues the realign command or when a stuffing error is reported. Either event flushes the FIFO and holds reads off until the delay has run out again. Between these events the HDSL frames run freely, driven only by the transmit enables, and further PCM syncs do not pull them back. The water level and the divisor are captured when the command is issued. Sticky overflow and underflow flags record misuse of the FIFO. All logic runs in one clock domain, with one-cycle enables for each written and each transmitted bit.

Top module: `wl_tx_bitfifo`

## Requirements
- R1: After reset the block is idle: no frame start, no read strobe, both flags clear. Master sync and transmit enables produce no frame start until the first realign command.
- R2: With captured divisor D (a value of 0 acts as 1), the PCM frame sync is the D-th master sync pulse counted from the last realign command or stuff error. Counting restarts at each of these events, and a master sync in the same cycle as one of them is not counted.
- R3: With captured water level W, `frame_start` is high for one cycle, on the cycle after the W-th transmit enable that follows the PCM frame sync. A transmit enable in the sync cycle itself is not counted. With W = 0, `frame_start` is high on the cycle after the sync.
- R4: The water level and the divisor are captured only on `realign_cmd`. A later change of `wl_cfg` or `div_cfg`, and a stuff error, leave the captured values unchanged.
- R5: `realign_cmd` or `stuff_err` empties the FIFO and stops reads until the next release. A write presented in the same cycle is discarded.
- R6: Once released, each frame lasts 16 + L transmit enables, where L is `blk_len_cfg`. `frame_start` rises after the last enable of a frame. PCM syncs during this time have no effect on the frame timing.
- R7: The first 16 transmit enables of every frame read nothing. The next L enables each read one bit.
- R8: Bits leave in the order they were accepted. `rd_vld` is high on the cycle after the reading enable, with `rd_bit` valid in that cycle.
- R9: A write is accepted when the fill is below min(186, L), or when a read takes a bit in the same cycle. Otherwise the write is dropped and `ovf_flag` is set.
- R10: A read while the FIFO is empty gives no `rd_vld` and sets `unf_flag`.
- R11: Both flags are sticky. Only `realign_cmd` (or reset) clears them; a stuff error does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msync_i | input | 1 | Master sync pulse |
| div_cfg | input | DIV_W | Master sync divisor |
| wl_cfg | input | WL_W | Water level in transmit enables |
| blk_len_cfg | input | LEN_W | Payload block length in bits |
| realign_cmd | input | 1 | Flush, capture settings, clear flags |
| stuff_err | input | 1 | Stuffing error: flush and realign |
| wr_vld | input | 1 | PCM-side bit write strobe |
| wr_bit | input | 1 | PCM-side data bit |
| tx_en | input | 1 | Transmit clock enable |
| rd_bit | output | 1 | Payload bit out |
| rd_vld | output | 1 | `rd_bit` carries a bit |
| frame_start | output | 1 | One-cycle HDSL frame start pulse |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
A PCM write and an HDSL payload read can fall in the same cycle. The case that matters is a FIFO at its limit, where the read must free the slot that the write then takes. The bench fills a short block to exactly its limit, releases it with a zero water level, and then writes only during the payload enables, so that every write coincides with a read. It expects the overflow flag to stay clear and the scoreboard to see every bit in order. A second coincidence, a write together with the realign command, must lose the write, and this shows up later as the order of the bits read out.

// File: rtl/txa_pkg.sv
package txa_pkg;

  typedef enum logic [1:0] {
    AL_IDLE,
    AL_ARM,
    AL_DELAY,
    AL_RUN
  } align_state_e;

  // Usable depth: the smaller of the physical store and the block length.
  function automatic int unsigned fill_limit(int unsigned depth, int unsigned len);
    return (len < depth) ? len : depth;
  endfunction

  // Index of the final bit time in a frame of overhead plus payload.
  function automatic int unsigned frame_last(int unsigned oh, int unsigned len);
    return oh + len - 1;
  endfunction

  // Circular pointer advance.
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/txa_sync_div.sv
module txa_sync_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             msync,
  output logic             pcm_sync
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             at_last;

  assign at_last  = (div_q <= DIV_W'(1)) ? (cnt_q == '0) : (cnt_q == div_q - 1'b1);
  assign pcm_sync = msync && at_last && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(1);
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      if (load) div_q <= div_in;
    end else if (msync) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/txa_align_ctl.sv
module txa_align_ctl
  import txa_pkg::*;
#(
  parameter int WL_W    = 8,
  parameter int LEN_W   = 8,
  parameter int OH_BITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             load,
  input  logic [WL_W-1:0]  wl_in,
  input  logic [LEN_W-1:0] len_cfg,
  input  logic             pcm_sync,
  input  logic             tx_en,
  output logic             frame_start,
  output logic             rd_take,
  output logic             in_overhead
);

  localparam int POS_W = $clog2(OH_BITS + (1 << LEN_W));

  align_state_e     st_q;
  logic [WL_W-1:0]  wl_q;
  logic [WL_W-1:0]  dcnt_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] last_pos;
  logic             fs_q;
  logic             running;

  assign last_pos    = POS_W'(frame_last(OH_BITS, 32'(len_cfg)));
  assign running     = (st_q == AL_RUN);
  assign in_overhead = running && (pos_q < POS_W'(OH_BITS));
  assign rd_take     = tx_en && !flush && running &&
                       (pos_q >= POS_W'(OH_BITS)) && (pos_q <= last_pos);
  assign frame_start = fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= AL_IDLE;
      wl_q   <= '0;
      dcnt_q <= '0;
      pos_q  <= '0;
      fs_q   <= 1'b0;
    end else begin
      fs_q <= 1'b0;
      if (flush) begin
        st_q   <= AL_ARM;
        dcnt_q <= '0;
        pos_q  <= '0;
        if (load) wl_q <= wl_in;
      end else begin
        unique case (st_q)
          AL_IDLE: begin
          end
          AL_ARM: begin
            if (pcm_sync) begin
              if (wl_q == '0) begin
                st_q  <= AL_RUN;
                pos_q <= '0;
                fs_q  <= 1'b1;
              end else begin
                st_q   <= AL_DELAY;
                dcnt_q <= '0;
              end
            end
          end
          AL_DELAY: begin
            if (tx_en) begin
              if (dcnt_q == wl_q - 1'b1) begin
                st_q  <= AL_RUN;
                pos_q <= '0;
                fs_q  <= 1'b1;
              end else begin
                dcnt_q <= dcnt_q + 1'b1;
              end
            end
          end
          AL_RUN: begin
            if (tx_en) begin
              if (pos_q >= last_pos) begin
                pos_q <= '0;
                fs_q  <= 1'b1;
              end else begin
                pos_q <= pos_q + 1'b1;
              end
            end
          end
          default: st_q <= AL_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/txa_bit_ring.sv
module txa_bit_ring
  import txa_pkg::*;
#(
  parameter int DEPTH = 186,
  parameter int LEN_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_req,
  input  logic             push_bit,
  input  logic             pop_req,
  input  logic [LEN_W-1:0] len_cfg,
  output logic             out_bit,
  output logic             out_vld,
  output logic [CNT_W-1:0] fill,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             ovf_evt,
  output logic             unf_evt
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0] mem_q;
  logic [PTR_W-1:0] wp_q;
  logic [PTR_W-1:0] rp_q;
  logic [CNT_W-1:0] fill_q;
  logic [CNT_W-1:0] limit;

  assign limit   = CNT_W'(fill_limit(DEPTH, 32'(len_cfg)));
  assign pop_ok  = pop_req && !flush && (fill_q != '0);
  assign push_ok = push_req && !flush && ((fill_q < limit) || pop_ok);
  assign ovf_evt = push_req && !flush && !push_ok;
  assign unf_evt = pop_req && !flush && (fill_q == '0);
  assign fill    = fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (push_ok) begin
      mem_q[wp_q] <= push_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      fill_q  <= '0;
      out_vld <= 1'b0;
      out_bit <= 1'b0;
    end else if (flush) begin
      wp_q    <= '0;
      rp_q    <= '0;
      fill_q  <= '0;
      out_vld <= 1'b0;
      out_bit <= 1'b0;
    end else begin
      out_vld <= pop_ok;
      out_bit <= pop_ok ? mem_q[rp_q] : 1'b0;
      if (push_ok) wp_q <= PTR_W'(wrap_inc(32'(wp_q), DEPTH));
      if (pop_ok)  rp_q <= PTR_W'(wrap_inc(32'(rp_q), DEPTH));
      unique case ({push_ok, pop_ok})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

endmodule

// File: rtl/wl_tx_bitfifo.sv
module wl_tx_bitfifo #(
  parameter int DEPTH   = 186,
  parameter int DIV_W   = 8,
  parameter int WL_W    = 8,
  parameter int LEN_W   = 8,
  parameter int OH_BITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msync_i,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [WL_W-1:0]  wl_cfg,
  input  logic [LEN_W-1:0] blk_len_cfg,
  input  logic             realign_cmd,
  input  logic             stuff_err,
  input  logic             wr_vld,
  input  logic             wr_bit,
  input  logic             tx_en,
  output logic             rd_bit,
  output logic             rd_vld,
  output logic             frame_start,
  output logic             ovf_flag,
  output logic             unf_flag
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  // Named internal events, visible to the bound checker.
  logic             flush;
  logic             pcm_sync;
  logic             rd_take;
  logic             in_overhead;
  logic [CNT_W-1:0] fill;
  logic             push_ok;
  logic             pop_ok;
  logic             ovf_evt;
  logic             unf_evt;

  assign flush = realign_cmd || stuff_err;

  txa_sync_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (flush),
    .load     (realign_cmd),
    .div_in   (div_cfg),
    .msync    (msync_i),
    .pcm_sync (pcm_sync)
  );

  txa_align_ctl #(.WL_W(WL_W), .LEN_W(LEN_W), .OH_BITS(OH_BITS)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .load        (realign_cmd),
    .wl_in       (wl_cfg),
    .len_cfg     (blk_len_cfg),
    .pcm_sync    (pcm_sync),
    .tx_en       (tx_en),
    .frame_start (frame_start),
    .rd_take     (rd_take),
    .in_overhead (in_overhead)
  );

  txa_bit_ring #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push_req (wr_vld),
    .push_bit (wr_bit),
    .pop_req  (rd_take),
    .len_cfg  (blk_len_cfg),
    .out_bit  (rd_bit),
    .out_vld  (rd_vld),
    .fill     (fill),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .ovf_evt  (ovf_evt),
    .unf_evt  (unf_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else if (realign_cmd) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      if (ovf_evt) ovf_flag <= 1'b1;
      if (unf_evt) unf_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/txa_checker.sv
module txa_checker
  import txa_pkg::*;
#(
  parameter int DEPTH = 186,
  parameter int LEN_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             realign_cmd,
  input logic             wr_vld,
  input logic             tx_en,
  input logic             in_overhead,
  input logic             rd_take,
  input logic [LEN_W-1:0] blk_len_cfg,
  input logic [CNT_W-1:0] fill,
  input logic             rd_vld,
  input logic             ovf_flag,
  input logic             unf_flag
);

  logic [CNT_W-1:0] lim_w;
  assign lim_w = CNT_W'(fill_limit(DEPTH, 32'(blk_len_cfg)));

  assert_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill == '0 && !rd_vld));

  assert_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && in_overhead) |=> !rd_vld);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && !flush && fill >= lim_w && !(rd_take && fill != '0)) |=> ovf_flag);

  assert_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  assert_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && fill == '0) |=> (unf_flag && !rd_vld));

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_flag || unf_flag) && !realign_cmd) |=> (ovf_flag || unf_flag));

endmodule

bind wl_tx_bitfifo txa_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .realign_cmd (realign_cmd),
  .wr_vld      (wr_vld),
  .tx_en       (tx_en),
  .in_overhead (in_overhead),
  .rd_take     (rd_take),
  .blk_len_cfg (blk_len_cfg),
  .fill        (fill),
  .rd_vld      (rd_vld),
  .ovf_flag    (ovf_flag),
  .unf_flag    (unf_flag)
);

// File: tb/wl_tx_bitfifo_test.sv
`timescale 1ns/1ps
module wl_tx_bitfifo_test;

  localparam int OH = 16;
  localparam int DP = 186;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       msync_i = 1'b0;
  logic [7:0] div_cfg = 8'd0;
  logic [7:0] wl_cfg = 8'd0;
  logic [7:0] blk_len_cfg = 8'd0;
  logic       realign_cmd = 1'b0;
  logic       stuff_err = 1'b0;
  logic       wr_vld = 1'b0;
  logic       wr_bit = 1'b0;
  logic       tx_en = 1'b0;
  logic       rd_bit, rd_vld, frame_start, ovf_flag, unf_flag;

  wl_tx_bitfifo uut (
    .clk(clk), .rst_n(rst_n), .msync_i(msync_i), .div_cfg(div_cfg),
    .wl_cfg(wl_cfg), .blk_len_cfg(blk_len_cfg), .realign_cmd(realign_cmd),
    .stuff_err(stuff_err), .wr_vld(wr_vld), .wr_bit(wr_bit), .tx_en(tx_en),
    .rd_bit(rd_bit), .rd_vld(rd_vld), .frame_start(frame_start),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  always #2.5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit sb_q[$];
  int mf = 0;
  int cur_len = 0;
  bit mrun = 0;
  int mpos = 0;
  bit mov = 0;
  bit mun = 0;
  bit s_fs = 0;
  logic [7:0] bs = 8'hA5;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit nb();
    bs = {bs[6:0], bs[7] ^ bs[5] ^ bs[4] ^ bs[3]};
    return bs[0];
  endfunction

  function automatic int lim();
    return (cur_len < DP) ? cur_len : DP;
  endfunction

  // Driver and reference model: one clock per call.
  task automatic tick(input bit wv, input bit wb, input bit te, input bit ms,
                      input bit cmd, input bit se);
    bit pop, popok, efs;
    string tag;
    @(negedge clk);
    wr_vld = wv; wr_bit = wb; tx_en = te; msync_i = ms;
    realign_cmd = cmd; stuff_err = se;
    @(posedge clk);
    #1;
    popok = 0; efs = 0;
    tag = (mrun && mpos < OH) ? "R7 overhead read" : "R8 read strobe";
    if (cmd || se) begin
      mf = 0; sb_q.delete(); mrun = 0; mpos = 0;
      if (cmd) begin mov = 0; mun = 0; end
      chk(frame_start == 0, "R5 no frame start on flush", frame_start, 0);
    end else begin
      pop = mrun && te && mpos >= OH && mpos <= OH + cur_len - 1;
      popok = pop && mf > 0;
      if (pop && mf == 0) mun = 1;
      if (wv) begin
        if (mf < lim() || popok) begin sb_q.push_back(wb); mf++; end
        else mov = 1;
      end
      if (popok) mf--;
      if (mrun) begin
        if (te) begin
          efs = (mpos >= OH + cur_len - 1);
          mpos = efs ? 0 : mpos + 1;
        end
        chk(frame_start == efs, "R6 frame period", frame_start, efs);
      end else if (frame_start) begin
        mrun = 1; mpos = 0;
      end
    end
    chk(rd_vld == popok, tag, rd_vld, popok);
    chk(ovf_flag == mov, "R9 overflow flag", ovf_flag, mov);
    chk(unf_flag == mun, "R10 underflow flag", unf_flag, mun);
    s_fs = frame_start;
  endtask

  // Scoreboard monitor: bits leave in accepted order.
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      nchk++;
      if (sb_q.size() == 0) begin
        nerr++;
        $display("FAIL R8 unexpected bit actual=%0d expected=none", rd_bit);
      end else begin
        bit e;
        e = sb_q.pop_front();
        if (rd_bit !== e) begin
          nerr++;
          $display("FAIL R8 bit order actual=%0d expected=%0d", rd_bit, e);
        end
      end
    end
  end

  task automatic count_to_fs(input int exp, input string tag);
    int n;
    n = -1;
    for (int i = 1; i <= 30 && n < 0; i++) begin
      tick(1, nb(), 1, 0, 0, 0);
      if (s_fs) n = i;
    end
    chk(n == exp, tag, n, exp);
  endtask

  initial begin
    #200000;
    nerr++; nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(rd_vld == 0 && frame_start == 0, "R1 reset outputs", rd_vld | frame_start, 0);
    chk(ovf_flag == 0 && unf_flag == 0, "R1 reset flags", ovf_flag | unf_flag, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick(0, 0, 1, 1, 0, 0);
      chk(s_fs == 0, "R1 idle until realign", s_fs, 0);
    end

    // Alignment with D=3, W=5, L=40; a write with the command is lost (R5).
    div_cfg = 8'd3; wl_cfg = 8'd5; blk_len_cfg = 8'd40; cur_len = 40;
    tick(1, 1, 0, 0, 1, 0);
    for (int i = 0; i < 12; i++) begin
      tick(1, nb(), 1, (i == 2 || i == 6), 0, 0);
      chk(s_fs == 0, "R2 no sync before third pulse", s_fs, 0);
    end
    wl_cfg = 8'd2; div_cfg = 8'd1;   // must not take effect (R4)
    tick(0, 0, 0, 1, 0, 0);
    chk(s_fs == 0, "R3 no start in sync cycle", s_fs, 0);
    count_to_fs(5, "R3 water level delay");

    // Free-running frames with master syncs ignored (R6).
    for (int i = 0; i < 200; i++) tick((i % 4) != 3, nb(), 1, (i % 7) == 0, 0, 0);
    for (int i = 0; i < 80; i++) tick(0, 0, 1, 0, 0, 0);
    chk(unf_flag == 1, "R10 drained fifo underflows", unf_flag, 1);

    // Stuff error: flush, keep flags and captured settings.
    tick(1, 1, 0, 0, 0, 1);
    chk(unf_flag == 1, "R11 stuff error keeps flag", unf_flag, 1);
    tick(0, 0, 0, 1, 0, 0);
    chk(s_fs == 0, "R4 divisor kept", s_fs, 0);
    tick(0, 0, 0, 1, 0, 0);
    tick(0, 0, 0, 1, 0, 0);
    count_to_fs(5, "R4 water level kept");

    // Depth limit with a long block.
    blk_len_cfg = 8'd200; cur_len = 200;
    tick(0, 0, 0, 0, 1, 0);
    chk(unf_flag == 0 && ovf_flag == 0, "R11 realign clears flags", unf_flag | ovf_flag, 0);
    for (int i = 1; i <= 190; i++) begin
      tick(1, nb(), 0, 0, 0, 0);
      if (i == 186) chk(ovf_flag == 0, "R9 full at depth", ovf_flag, 0);
      if (i == 187) chk(ovf_flag == 1, "R9 write beyond depth", ovf_flag, 1);
    end

    // Short block, zero water level, write and read in the same cycle.
    blk_len_cfg = 8'd8; cur_len = 8; wl_cfg = 8'd0; div_cfg = 8'd1;
    tick(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 8; i++) tick(1, nb(), 0, 0, 0, 0);
    tick(0, 0, 0, 1, 0, 0);
    chk(s_fs == 1, "R3 zero water level start", s_fs, 1);
    for (int i = 0; i < 60; i++) tick(mrun && mpos >= OH, nb(), 1, 0, 0, 0);
    chk(ovf_flag == 0, "R9 read frees slot same cycle", ovf_flag, 0);
    for (int i = 0; i < 40; i++) tick(0, 0, 1, 0, 0, 0);
    chk(unf_flag == 1, "R10 empty read", unf_flag, 1);
    tick(0, 0, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule